// File: doc/BRIEF.md
# Grouped Interrupt Event and Mask Unit

This block keeps the interrupt state of a network controller. A 32-bit event register records conditions that the controller's hardware reports through a per-bit set pulse. A 32-bit mask register, written by software, selects which pending events may raise an interrupt. The event bits fall into three fixed groups: transmit, receive and error. Each group drives its own level-sensitive interrupt line, which is high while any event of that group is both pending and enabled.

Software reaches both registers through a single-cycle register port. Writing the event register clears the bits written as one. Writing the mask register replaces its whole value. The lines are re-evaluated from the register contents after every change, whatever caused it. An event that arrived while masked therefore raises its line as soon as software unmasks it. Two request inputs model graceful receive and transmit stops that complete at once; each sets its own stop-complete event bit.

Top module: `irq_grp_unit`

## Requirements
- R1: While reset is asserted, and after its synchronised release, the event register, the mask register and all three interrupt lines read zero.
- R2: A write to the event register (offset 0x0) clears every event bit written as one and leaves bits written as zero unchanged.
- R3: A write to the mask register (offset 0x4) replaces all implemented mask bits with the written data.
- R4: A one on `evt_set` sets that event bit. If a set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: Transmit line covers event bits 20 and 22. Receive line covers bits 7 and 15. Error line covers bits 8-14, 16-19 and 23-31. Each line goes high or low one cycle after the event/mask state that causes the change.
- R6: An event that is pending while masked raises its line once a mask write enables its bit, with no new event needed.
- R7: `stop_rx_req` sets event bit 8 (graceful receive stop complete). `stop_tx_req` sets event bit 23 (graceful transmit stop complete).
- R8: Bits 0-6 and 21 belong to no group. They read zero in both registers and never raise a line. Reads have no side effects, and an unmapped offset reads zero.
- R9: A line stays high while at least one active event of its group remains. It falls once software has cleared the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when set together with bus_sel |
| bus_addr | input | 4 | Byte offset: 0x0 event, 0x4 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| evt_set | input | 32 | Per-bit hardware event set pulses |
| stop_rx_req | input | 1 | Immediate graceful receive stop request |
| stop_tx_req | input | 1 | Immediate graceful transmit stop request |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The hardest case to reach is an event that becomes pending while its mask bit is clear and then raises its line purely because of a later mask write. The same goes for a set pulse landing in the very cycle that software clears the same bit. The bench sweeps all 32 bit positions. For each one it raises the event with the mask at zero and confirms that every line stays low. It then unmasks that single bit and compares all three lines against the group the bit belongs to, then clears the event and confirms the line falls. A separate step drives a set pulse and an all-ones clear in the same cycle and checks that the set survives.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned N_GRP  = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    GRP_TX  = 2'd0,
    GRP_RX  = 2'd1,
    GRP_ERR = 2'd2
  } grp_e;

  // positions tied to behaviour
  localparam int unsigned RXF_POS  = 7;
  localparam int unsigned GRSC_POS = 8;
  localparam int unsigned RXB_POS  = 15;
  localparam int unsigned RXC_POS  = 30;
  localparam int unsigned BABR_POS = 31;

  function automatic word_t bit_at(input int unsigned pos);
    word_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
  import irq_grp_pkg::*;
#(
  parameter word_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_vec,
  input  word_t clr_vec,
  output word_t evt_q
);
  word_t evt_d;
  logic  upd_en;

  always_comb begin
    upd_en = (|set_vec) | (|clr_vec);
    // set applied after clear: set wins
    evt_d  = ((evt_q & ~clr_vec) | set_vec) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (upd_en) evt_q <= evt_d;
  end

  // R4: every implemented bit pulsed is present next cycle
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & IMPL)) |=> ((evt_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

  // R2: cleared bits without a concurrent set are gone next cycle
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((evt_q & $past(clr_vec & ~set_vec)) == '0));

  // R2: with no set and no clear, the register holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_vec) && !(|clr_vec)) |=> $stable(evt_q));
endmodule

// File: rtl/irq_msk_reg.sv
module irq_msk_reg
  import irq_grp_pkg::*;
#(
  parameter word_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  word_t ld_val,
  output word_t msk_q
);
  word_t msk_d;

  always_comb msk_d = ld_val & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     msk_q <= '0;
    else if (ld_en) msk_q <= msk_d;
  end

  // R3: a load replaces the whole implemented value
  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (msk_q == $past(ld_val & IMPL)));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(msk_q));
endmodule

// File: rtl/irq_line_or.sv
module irq_line_or
  import irq_grp_pkg::*;
#(
  parameter int unsigned NG = N_GRP,
  parameter logic [NG*WORD_W-1:0] GRP_MAP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  word_t         evt_q,
  input  word_t         msk_q,
  output logic [NG-1:0] line_q
);
  word_t         active;
  logic [NG-1:0] line_d;

  always_comb active = evt_q & msk_q;

  for (genvar g = 0; g < NG; g++) begin : g_line
    always_comb line_d[g] = |(active & GRP_MAP[g*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/irq_grp_unit.sv
module irq_grp_unit
  import irq_grp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned EVT_OFF   = 0,
  parameter int unsigned MSK_OFF   = 4,
  parameter int unsigned TXF_POS   = 20,
  parameter int unsigned TXB_POS   = 22,
  parameter int unsigned GTSC_POS  = 23,
  parameter logic [31:0] ERR_OTHER = 32'h3F0F_7E00
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_set,
  input  logic              stop_rx_req,
  input  logic              stop_tx_req,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam word_t TX_GRP  = bit_at(TXF_POS) | bit_at(TXB_POS);
  localparam word_t RX_GRP  = bit_at(RXF_POS) | bit_at(RXB_POS);
  localparam word_t ERR_GRP = ERR_OTHER | bit_at(GTSC_POS) | bit_at(GRSC_POS)
                            | bit_at(RXC_POS) | bit_at(BABR_POS);
  localparam word_t IMPL    = TX_GRP | RX_GRP | ERR_GRP;
  localparam logic [N_GRP*WORD_W-1:0] GRP_MAP = {ERR_GRP, RX_GRP, TX_GRP};

  logic              rst_n;
  logic              hit_evt, hit_msk;
  logic              wr_evt, wr_msk;
  word_t             set_vec, clr_vec;
  word_t             evt_q, msk_q;
  logic [N_GRP-1:0]  line_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n_i), .rst_n_o(rst_n)
  );

  always_comb begin
    hit_evt = (bus_addr == ADDR_W'(EVT_OFF));
    hit_msk = (bus_addr == ADDR_W'(MSK_OFF));
    wr_evt  = bus_sel & bus_wr & hit_evt;
    wr_msk  = bus_sel & bus_wr & hit_msk;
    clr_vec = wr_evt ? bus_wdata : '0;
    set_vec = evt_set
            | (stop_rx_req ? bit_at(GRSC_POS) : '0)
            | (stop_tx_req ? bit_at(GTSC_POS) : '0);
  end

  irq_evt_reg #(.IMPL(IMPL)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .evt_q(evt_q)
  );

  irq_msk_reg #(.IMPL(IMPL)) u_msk (
    .clk(clk), .rst_n(rst_n), .ld_en(wr_msk), .ld_val(bus_wdata), .msk_q(msk_q)
  );

  irq_line_or #(.NG(N_GRP), .GRP_MAP(GRP_MAP)) u_or (
    .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .msk_q(msk_q), .line_q(line_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_evt)      bus_rdata = evt_q;
    else if (hit_msk) bus_rdata = msk_q;
    irq_tx  = line_q[GRP_TX];
    irq_rx  = line_q[GRP_RX];
    irq_err = line_q[GRP_ERR];
  end

  // R5: each line follows its group's active set with one cycle of delay
  p_tx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_tx == $past(|(evt_q & msk_q & TX_GRP))));
  p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_rx == $past(|(evt_q & msk_q & RX_GRP))));
  p_err_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_err == $past(|(evt_q & msk_q & ERR_GRP))));

  // R7: immediate stop requests record their completion bits
  p_stop_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rx_req |=> evt_q[GRSC_POS]);
  p_stop_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_tx_req |=> evt_q[GTSC_POS]);

  // R1: nothing is held while in reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (evt_q == '0 && msk_q == '0 && line_q == '0));
endmodule

// File: tb/irq_grp_unit_tb.sv
module irq_grp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n_i;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, evt_set;
  logic        stop_rx_req, stop_tx_req;
  logic        irq_tx, irq_rx, irq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // group layout taken from the requirements
  localparam logic [31:0] TXG  = (32'h1 << 20) | (32'h1 << 22);
  localparam logic [31:0] RXG  = (32'h1 << 7)  | (32'h1 << 15);
  localparam logic [31:0] ERRG = 32'h0000_7F00 | 32'h000F_0000 | 32'hFF80_0000;
  localparam logic [31:0] IMPL = TXG | RXG | ERRG;

  always #10 clk = ~clk;

  irq_grp_unit u_dut (
    .clk(clk), .rst_n_i(rst_n_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .stop_rx_req(stop_rx_req), .stop_tx_req(stop_tx_req),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] s);
    evt_set = s;
    tick();
    evt_set = '0;
  endtask

  function automatic logic [31:0] lines();
    return {29'd0, irq_err, irq_rx, irq_tx};
  endfunction

  function automatic logic [31:0] exp_lines(input logic [31:0] act);
    return {29'd0, |(act & ERRG), |(act & RXG), |(act & TXG)};
  endfunction

  initial begin
    logic [31:0] v, v2;
    rst_n_i = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    evt_set = 0; stop_rx_req = 0; stop_tx_req = 0;
    // R1: hardware pulses during reset are ignored
    tick(); evt_set = '1; tick(); tick(); evt_set = '0;
    rst_n_i = 1'b1;
    repeat (4) tick();
    rd(4'h0, v); chk(v, 32'h0, "R1 event after reset");
    rd(4'h4, v); chk(v, 32'h0, "R1 mask after reset");
    chk(lines(), 32'h0, "R1 lines after reset");

    // R3: full mask replacement and unused bits
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); chk(v, IMPL, "R3/R8 mask all ones");
    wr(4'h4, 32'h0000_0080);
    rd(4'h4, v); chk(v, 32'h0000_0080, "R3 mask replaced");
    wr(4'h4, 32'h0);

    // exhaustive sweep across bit positions: R2 R5 R6 R8
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pulse(b);
      rd(4'h0, v); chk(v, b & IMPL, $sformatf("R4/R8 event bit %0d", i));
      tick();
      chk(lines(), 32'h0, $sformatf("R6 masked bit %0d quiet", i));
      wr(4'h4, b);
      tick();
      chk(lines(), exp_lines(b & IMPL), $sformatf("R5/R6 unmask bit %0d", i));
      wr(4'h0, b);
      rd(4'h0, v); chk(v, 32'h0, $sformatf("R2 clear bit %0d", i));
      tick();
      chk(lines(), 32'h0, $sformatf("R9 line drop bit %0d", i));
      wr(4'h4, 32'h0);
    end

    // R2: zeros in the write keep bits
    pulse(32'h0050_8080);
    wr(4'h0, 32'h0040_0000);
    rd(4'h0, v); chk(v, 32'h0010_8080, "R2 partial clear");
    // R8: repeated read has no side effect; unmapped offset is zero
    rd(4'h0, v2); chk(v2, 32'h0010_8080, "R8 read no side effect");
    rd(4'h8, v); chk(v, 32'h0, "R8 unmapped offset");
    wr(4'h0, 32'hFFFF_FFFF);

    // R4: set and clear on the same bit in the same cycle
    pulse(32'h0050_0000);
    evt_set = 32'h0010_0000;
    wr(4'h0, 32'hFFFF_FFFF);
    evt_set = '0;
    rd(4'h0, v); chk(v, 32'h0010_0000, "R4 set wins over clear");
    wr(4'h0, 32'hFFFF_FFFF);

    // R9: line held while one active event remains
    wr(4'h4, TXG);
    pulse(TXG);
    tick(); chk(lines(), 32'h1, "R9 tx with two events");
    wr(4'h0, 32'h1 << 20);
    tick(); chk(lines(), 32'h1, "R9 tx with one left");
    wr(4'h0, 32'h1 << 22);
    tick(); chk(lines(), 32'h0, "R9 tx after last cleared");
    wr(4'h4, 32'h0);

    // R7: graceful stop completion bits
    stop_rx_req = 1'b1; tick(); stop_rx_req = 1'b0;
    rd(4'h0, v); chk(v, 32'h0000_0100, "R7 receive stop bit 8");
    stop_tx_req = 1'b1; tick(); stop_tx_req = 1'b0;
    rd(4'h0, v); chk(v, 32'h0080_0100, "R7 transmit stop bit 23");
    wr(4'h4, 32'h0080_0000);
    tick(); chk(lines(), 32'h4, "R7/R6 error line on unmask");
    wr(4'h0, 32'h0080_0000);
    tick(); chk(lines(), 32'h0, "R7 error line after clear");

    // R1: reset mid-run wipes state
    wr(4'h4, 32'h0000_0100);
    tick();
    chk(lines(), 32'h4, "R5 error line before reset");
    rst_n_i = 1'b0; tick();
    rd(4'h0, v); chk(v, 32'h0, "R1 event in reset");
    chk(lines(), 32'h0, "R1 lines in reset");
    rst_n_i = 1'b1; repeat (4) tick();
    rd(4'h4, v); chk(v, 32'h0, "R1 mask after second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule